// File: doc/BRIEF.md
# Protection Controller Configuration Register File

This block is the 32-bit register file behind a memory protection controller that splits memory into fixed-size blocks and marks each block secure or non-secure. Software reaches it over a simple register bus with byte, halfword and word accesses. It holds a control word, a table of per-block security bit words reached through an index register, two read-only geometry registers, and an interrupt group with status, enable, set, clear and two fault-information words. The block drives a level interrupt and the selected response mode for security violations.

The table is reached one word at a time. Software writes the index once. After that it can stream words in or out, because each full-word table access can advance the index by one, and the index wraps at the table depth. A sticky lockdown bit freezes the control word, the table and the interrupt enable until the next reset. Filtering of downstream traffic and capture of fault details belong to other logic. The fault-information words therefore read as zero here.

Top module: `mpc_cfg_regs`

## Requirements
- R1: After reset the control word reads 0x00000100, index 0, status 0, enable 1, both fault words 0, every table word 0, and `irq` is low.
- R2: The control word (offset 0x00) keeps only bit 4 (violation response select, driven on `sec_resp_sel`), bit 8 (index auto-advance) and bit 31 (lockdown). Every other bit reads zero and ignores writes.
- R3: Offset 0x10 reads TABLE_DEPTH and offset 0x14 reads log2(BLOCK_BYTES)-5. Both ignore writes. The fault words at 0x2C and 0x30 and every unmapped offset read zero.
- R4: A write to the index register (0x18) stores the merged written value modulo TABLE_DEPTH.
- R5: An access to offset 0x1C reads or writes the table word at the current index. When auto-advance is set and the access is a word (`req_size` 2 or 3), the index then steps by one and wraps from TABLE_DEPTH-1 to 0. Byte and halfword accesses never step it.
- R6: Write data is lane-aligned: byte lane n is `req_wdata[8n+7:8n]`, `req_size` 0 is a byte at lane `req_addr[1:0]`, and 1 is a halfword at lanes `2*req_addr[1]` and up. A sub-word write to the control word, index or table merges into the current value. A sub-word write to any other register merges into zero.
- R7: A write whose merged bit 0 is 1 sets the status bit at 0x34 and clears it at 0x24. A merged bit 0 of 0 has no effect. Status reads at 0x20.
- R8: The enable register (0x28) holds only bit 0 of the merged write. `irq` equals status AND enable from the edge that completes the changing write.
- R9: While lockdown is set, writes to the control word, table and enable have no effect, and a blocked table write does not step the index. Index writes, status set/clear and table reads still act. Only reset clears lockdown.
- R10: Every cycle with `req_valid` high is one access. On the next clock edge `rsp_ready` is high for one cycle, with `rsp_rdata` carrying the read word, or zero for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, one access per cycle high |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_wdata | input | 32 | Lane-aligned write data |
| rsp_ready | output | 1 | Access complete |
| rsp_rdata | output | 32 | Read data |
| sec_resp_sel | output | 1 | Violation response select (control bit 4) |
| irq | output | 1 | Interrupt: status AND enable |

## Verification
Seeded random accesses cover every offset and every size. They separate lane merging into the current value from merging into zero, and word accesses, which step the index, from sub-word ones, which do not. Index writes use large random values, which expose a missing modulo for a depth that is not a power of two. Directed runs stream past the last table word to show the wrap. Other directed runs toggle status and enable in several orders, so that `irq` is seen to follow both inputs. A final lockdown sequence separates the frozen registers from those that stay live, including the step that must be skipped on a blocked table write.

// File: rtl/mpc_cfg_pkg.sv
package mpc_cfg_pkg;
   localparam logic [7:0] OFS_CTRL   = 8'h00;
   localparam logic [7:0] OFS_DEPTH  = 8'h10;
   localparam logic [7:0] OFS_GEOM   = 8'h14;
   localparam logic [7:0] OFS_INDEX  = 8'h18;
   localparam logic [7:0] OFS_TABLE  = 8'h1C;
   localparam logic [7:0] OFS_STAT   = 8'h20;
   localparam logic [7:0] OFS_CLEAR  = 8'h24;
   localparam logic [7:0] OFS_ENABLE = 8'h28;
   localparam logic [7:0] OFS_FAULT0 = 8'h2C;
   localparam logic [7:0] OFS_FAULT1 = 8'h30;
   localparam logic [7:0] OFS_SET    = 8'h34;

   localparam logic [31:0] CTRL_KEEP  = 32'h8000_0110;
   localparam logic [31:0] CTRL_RESET = 32'h0000_0100;
   localparam int unsigned BIT_RESP   = 4;
   localparam int unsigned BIT_ADV    = 8;
   localparam int unsigned BIT_LOCK   = 31;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WRD3 = 2'd3
   } acc_size_e;
endpackage

// File: rtl/mpc_cfg_lane_merge.sv
module mpc_cfg_lane_merge
   import mpc_cfg_pkg::*;
(
   input  logic [1:0]  size,
   input  logic [1:0]  lane,
   input  logic [31:0] base,
   input  logic [31:0] wdata,
   output logic [31:0] merged
);
   logic [31:0] mask;

   always_comb begin
      unique case (acc_size_e'(size))
         SZ_BYTE: mask = 32'h0000_00FF << {lane, 3'b000};
         SZ_HALF: mask = 32'h0000_FFFF << {lane[1], 4'b0000};
         default: mask = 32'hFFFF_FFFF;
      endcase
      merged = (base & ~mask) | (wdata & mask);
   end
endmodule

// File: rtl/mpc_cfg_lut.sv
module mpc_cfg_lut #(
   parameter int unsigned TABLE_DEPTH = 12
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        idx_wr_en,
   input  logic [31:0] idx_wr_val,
   input  logic        word_wr_en,
   input  logic [31:0] word_wr_val,
   input  logic        step,
   output logic [31:0] cur_idx,
   output logic [31:0] cur_word
);
   localparam int unsigned IDX_W = (TABLE_DEPTH > 1) ? $clog2(TABLE_DEPTH) : 1;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(TABLE_DEPTH - 1);
   localparam bit IS_POW2 = (TABLE_DEPTH & (TABLE_DEPTH - 1)) == 0;

   logic [IDX_W-1:0] idx_q, idx_d, idx_mod;
   logic [31:0]      table_q [TABLE_DEPTH];

   generate
      if (IS_POW2) begin : g_mask_mod
         assign idx_mod = idx_wr_val[IDX_W-1:0];
      end else begin : g_div_mod
         assign idx_mod = IDX_W'(idx_wr_val % 32'(TABLE_DEPTH));
      end
   endgenerate

   always_comb begin
      idx_d = idx_q;
      if (idx_wr_en)  idx_d = idx_mod;
      else if (step)  idx_d = (idx_q == LAST) ? '0 : idx_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         for (int i = 0; i < int'(TABLE_DEPTH); i++) table_q[i] <= '0;
      end else begin
         idx_q <= idx_d;
         if (word_wr_en) table_q[idx_q] <= word_wr_val;
      end
   end

   assign cur_idx  = 32'(idx_q);
   assign cur_word = table_q[idx_q];

   // R4
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cur_idx < 32'(TABLE_DEPTH));

   // R5
   step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !idx_wr_en && idx_q == LAST) |=> (cur_idx == 32'd0));
endmodule

// File: rtl/mpc_cfg_irq.sv
module mpc_cfg_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic set_pulse,
   input  logic clr_pulse,
   input  logic en_wr,
   input  logic en_val,
   output logic stat,
   output logic en,
   output logic irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat <= 1'b0;
         en   <= 1'b1;
      end else begin
         if (set_pulse)      stat <= 1'b1;
         else if (clr_pulse) stat <= 1'b0;
         if (en_wr)          en   <= en_val;
      end
   end

   assign irq = stat & en;

   // R7
   stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_pulse |=> stat);

   // R7
   stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_pulse && !set_pulse) |=> !stat);

   // R8
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(set_pulse || en_wr));
endmodule

// File: rtl/mpc_cfg_regs.sv
module mpc_cfg_regs
   import mpc_cfg_pkg::*;
#(
   parameter int unsigned TABLE_DEPTH = 12,
   parameter int unsigned BLOCK_BYTES = 128,
   parameter int unsigned ADDR_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic [31:0]       req_wdata,
   output logic              rsp_ready,
   output logic [31:0]       rsp_rdata,
   output logic              sec_resp_sel,
   output logic              irq
);
   localparam logic [31:0] DEPTH_VAL = 32'(TABLE_DEPTH);
   localparam logic [31:0] GEOM_VAL  = 32'($clog2(BLOCK_BYTES) - 5);

   generate
      if (TABLE_DEPTH < 2) begin : g_bad_depth
         $error("TABLE_DEPTH must be at least 2");
      end
      if (BLOCK_BYTES < 32 || (BLOCK_BYTES & (BLOCK_BYTES - 1)) != 0) begin : g_bad_block
         $error("BLOCK_BYTES must be a power of two of at least 32");
      end
      if (ADDR_W < 6) begin : g_bad_addr
         $error("ADDR_W must cover offset 0x34");
      end
   endgenerate

   logic [ADDR_W-1:0] woff;
   logic              wr, rd, is_word, locked, adv_on;
   logic              hit_ctrl, hit_idx, hit_tab, hit_clr, hit_en, hit_set;
   logic [31:0]       ctrl_q, base_val, merged, rd_val;
   logic [31:0]       cur_idx, cur_word;
   logic              tab_wr_en, step, stat, en_q;

   assign woff     = {req_addr[ADDR_W-1:2], 2'b00};
   assign wr       = req_valid && req_write;
   assign rd       = req_valid && !req_write;
   assign is_word  = req_size[1];
   assign locked   = ctrl_q[BIT_LOCK];
   assign adv_on   = ctrl_q[BIT_ADV];

   assign hit_ctrl = woff == ADDR_W'(OFS_CTRL);
   assign hit_idx  = woff == ADDR_W'(OFS_INDEX);
   assign hit_tab  = woff == ADDR_W'(OFS_TABLE);
   assign hit_clr  = woff == ADDR_W'(OFS_CLEAR);
   assign hit_en   = woff == ADDR_W'(OFS_ENABLE);
   assign hit_set  = woff == ADDR_W'(OFS_SET);

   always_comb begin
      if (hit_ctrl)     base_val = ctrl_q;
      else if (hit_idx) base_val = cur_idx;
      else if (hit_tab) base_val = cur_word;
      else              base_val = '0;
   end

   mpc_cfg_lane_merge u_merge (
      .size   (req_size),
      .lane   (req_addr[1:0]),
      .base   (base_val),
      .wdata  (req_wdata),
      .merged (merged)
   );

   assign tab_wr_en = wr && hit_tab && !locked;
   assign step      = req_valid && hit_tab && is_word && adv_on && (rd || !locked);

   mpc_cfg_lut #(.TABLE_DEPTH(TABLE_DEPTH)) u_lut (
      .clk         (clk),
      .rst_n       (rst_n),
      .idx_wr_en   (wr && hit_idx),
      .idx_wr_val  (merged),
      .word_wr_en  (tab_wr_en),
      .word_wr_val (merged),
      .step        (step),
      .cur_idx     (cur_idx),
      .cur_word    (cur_word)
   );

   mpc_cfg_irq u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_pulse (wr && hit_set && merged[0]),
      .clr_pulse (wr && hit_clr && merged[0]),
      .en_wr     (wr && hit_en && !locked),
      .en_val    (merged[0]),
      .stat      (stat),
      .en        (en_q),
      .irq       (irq)
   );

   always_comb begin
      unique case (woff)
         ADDR_W'(OFS_CTRL):   rd_val = ctrl_q;
         ADDR_W'(OFS_DEPTH):  rd_val = DEPTH_VAL;
         ADDR_W'(OFS_GEOM):   rd_val = GEOM_VAL;
         ADDR_W'(OFS_INDEX):  rd_val = cur_idx;
         ADDR_W'(OFS_TABLE):  rd_val = cur_word;
         ADDR_W'(OFS_STAT):   rd_val = {31'd0, stat};
         ADDR_W'(OFS_ENABLE): rd_val = {31'd0, en_q};
         default:             rd_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= CTRL_RESET;
         rsp_ready <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         if (wr && hit_ctrl && !locked) ctrl_q <= merged & CTRL_KEEP;
         rsp_ready <= req_valid;
         rsp_rdata <= rd ? rd_val : '0;
      end
   end

   assign sec_resp_sel = ctrl_q[BIT_RESP];

   // R10
   rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (rsp_ready == $past(req_valid)));

   // R9
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> locked);

   // R9
   lock_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(ctrl_q));

   // R9
   lock_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && wr && hit_tab) |=> $stable(cur_idx) && $stable(cur_word));
endmodule

// File: tb/mpc_cfg_regs_bench.sv
`timescale 1ns/1ps
module mpc_cfg_regs_bench;
   localparam int unsigned DEPTH = 12;
   localparam int unsigned BLK   = 128;
   localparam int unsigned AW    = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [1:0]    req_size = 2'd2;
   logic [31:0]   req_wdata = '0;
   logic          rsp_ready, sec_resp_sel, irq;
   logic [31:0]   rsp_rdata;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   logic [31:0] m_ctrl;
   int          m_idx;
   logic [31:0] m_lut [DEPTH];
   bit          m_stat, m_en;

   always #2.5 clk = ~clk;

   mpc_cfg_regs #(.TABLE_DEPTH(DEPTH), .BLOCK_BYTES(BLK), .ADDR_W(AW)) u_mpc_cfg_regs (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
      .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
      .sec_resp_sel(sec_resp_sel), .irq(irq));

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] lanes(input logic [1:0] sz, input logic [1:0] lo);
      if (sz == 2'd0) return 32'hFF << (8 * lo);
      if (sz == 2'd1) return 32'hFFFF << (16 * lo[1]);
      return 32'hFFFF_FFFF;
   endfunction

   // Model of the register file following R2..R9; returns the expected read word.
   task automatic model(input bit w, input logic [7:0] a, input logic [1:0] sz,
                        input logic [31:0] d, output logic [31:0] exp);
      logic [31:0] mk, mz;
      bit lk, step;
      mk = lanes(sz, a[1:0]);
      mz = d & mk;
      lk = m_ctrl[31];
      step = 0;
      exp = 32'd0;
      case (a & 8'hFC)
         8'h00: if (!w) exp = m_ctrl;
                else if (!lk) m_ctrl = ((m_ctrl & ~mk) | mz) & 32'h8000_0110;
         8'h10: if (!w) exp = DEPTH;
         8'h14: if (!w) exp = 32'd2;
         8'h18: if (!w) exp = 32'(m_idx);
                else m_idx = int'((((32'(m_idx)) & ~mk) | mz) % DEPTH);
         8'h1C: if (!w) begin exp = m_lut[m_idx]; step = 1; end
                else if (!lk) begin m_lut[m_idx] = (m_lut[m_idx] & ~mk) | mz; step = 1; end
         8'h20: if (!w) exp = {31'd0, m_stat};
         8'h24: if (w && mz[0]) m_stat = 0;
         8'h28: if (!w) exp = {31'd0, m_en};
                else if (!lk) m_en = mz[0];
         8'h34: if (w && mz[0]) m_stat = 1;
         default: ;
      endcase
      if (step && sz[1] && m_ctrl[8]) m_idx = (m_idx + 1) % DEPTH;
   endtask

   task automatic acc(input bit w, input logic [7:0] a, input logic [1:0] sz,
                      input logic [31:0] d, input string tag);
      logic [31:0] exp, got;
      logic        rdy, ir;
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_addr = a; req_size = sz; req_wdata = d;
      @(posedge clk);
      #1;
      got = rsp_rdata; rdy = rsp_ready; ir = irq;
      req_valid = 1'b0;
      model(w, a, sz, d, exp);
      // R10: one-cycle response with read data, zero for writes
      chk(rdy === 1'b1, "R10", {31'd0, rdy}, 32'd1);
      chk(got === exp, tag, got, exp);
      // R8: irq tracks status AND enable
      chk(ir === (m_stat & m_en), "R8", {31'd0, ir}, {31'd0, m_stat & m_en});
      chk(sec_resp_sel === m_ctrl[4], "R2", {31'd0, sec_resp_sel}, {31'd0, m_ctrl[4]});
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] offs [12];
      void'($urandom(32'd2024));
      offs = '{8'h00, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24, 8'h28, 8'h2C, 8'h30, 8'h34, 8'h40};
      m_ctrl = 32'h100; m_idx = 0; m_stat = 0; m_en = 1;
      for (int i = 0; i < int'(DEPTH); i++) m_lut[i] = 32'd0;

      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      // R1: idle outputs after reset
      chk(irq === 1'b0, "R1", {31'd0, irq}, 32'd0);
      chk(rsp_ready === 1'b0, "R1", {31'd0, rsp_ready}, 32'd0);

      // R1, R3: reset values and read-only registers
      acc(0, 8'h00, 2'd2, 0, "R1");
      chk(rsp_rdata === 32'h100, "R1", rsp_rdata, 32'h100);
      acc(0, 8'h18, 2'd2, 0, "R1");
      acc(0, 8'h20, 2'd2, 0, "R1");
      acc(0, 8'h28, 2'd2, 0, "R1");
      chk(rsp_rdata === 32'd1, "R1", rsp_rdata, 32'd1);
      acc(0, 8'h2C, 2'd2, 0, "R3");
      acc(0, 8'h30, 2'd2, 0, "R3");
      acc(0, 8'h10, 2'd2, 0, "R3");
      chk(rsp_rdata === 32'd12, "R3", rsp_rdata, 32'd12);
      acc(0, 8'h14, 2'd2, 0, "R3");
      chk(rsp_rdata === 32'd2, "R3", rsp_rdata, 32'd2);
      acc(1, 8'h10, 2'd2, 32'h55, "R3");
      acc(0, 8'h10, 2'd2, 0, "R3");
      acc(0, 8'h44, 2'd2, 0, "R3");
      // R1, R5: stream whole table (all zero), index wraps back to 0
      for (int i = 0; i < int'(DEPTH); i++) acc(0, 8'h1C, 2'd2, 0, "R1");
      acc(0, 8'h18, 2'd2, 0, "R5");
      chk(rsp_rdata === 32'd0, "R5", rsp_rdata, 32'd0);

      // R2: reserved control bits
      acc(1, 8'h00, 2'd2, 32'h7FFF_FEFF, "R2");
      acc(0, 8'h00, 2'd2, 0, "R2");
      chk(rsp_rdata === 32'h10, "R2", rsp_rdata, 32'h10);
      // R6: byte write to lane 1 of control merges with current value
      acc(1, 8'h01, 2'd0, 32'h0000_0100, "R6");
      acc(0, 8'h00, 2'd2, 0, "R6");
      chk(rsp_rdata === 32'h110, "R6", rsp_rdata, 32'h110);

      // R4: modulo on index write
      acc(1, 8'h18, 2'd2, 32'd13, "R4");
      acc(0, 8'h18, 2'd2, 0, "R4");
      chk(rsp_rdata === 32'd1, "R4", rsp_rdata, 32'd1);
      acc(1, 8'h18, 2'd2, 32'hFFFF_FFFF, "R4");
      acc(0, 8'h18, 2'd2, 0, "R4");
      chk(rsp_rdata === 32'd3, "R4", rsp_rdata, 32'd3);

      // R5: streaming writes across the wrap, sub-word no step
      acc(1, 8'h18, 2'd2, 32'd10, "R5");
      acc(1, 8'h1C, 2'd2, 32'hA0A0_0001, "R5");
      acc(1, 8'h1C, 2'd2, 32'hB0B0_0002, "R5");
      acc(1, 8'h1C, 2'd2, 32'hC0C0_0003, "R5");
      acc(0, 8'h18, 2'd2, 0, "R5");
      chk(rsp_rdata === 32'd1, "R5", rsp_rdata, 32'd1);
      acc(1, 8'h1E, 2'd1, 32'h1234_0000, "R6");
      acc(1, 8'h1C, 2'd0, 32'h0000_0077, "R6");
      acc(0, 8'h18, 2'd2, 0, "R5");
      acc(1, 8'h18, 2'd2, 32'd1, "R5");
      acc(0, 8'h1C, 2'd2, 0, "R6");
      chk(rsp_rdata === 32'h1234_0077, "R6", rsp_rdata, 32'h1234_0077);
      acc(1, 8'h18, 2'd2, 32'd0, "R5");
      acc(0, 8'h1C, 2'd2, 0, "R5");
      chk(rsp_rdata === 32'hC0C0_0003, "R5", rsp_rdata, 32'hC0C0_0003);
      // R5: auto-advance off keeps index
      acc(1, 8'h00, 2'd2, 32'h0, "R5");
      acc(0, 8'h1C, 2'd2, 0, "R5");
      acc(0, 8'h18, 2'd2, 0, "R5");
      chk(rsp_rdata === 32'd1, "R5", rsp_rdata, 32'd1);
      acc(1, 8'h00, 2'd2, 32'h100, "R5");

      // R7, R8: status and enable interplay
      acc(1, 8'h34, 2'd2, 32'h2, "R7");
      acc(1, 8'h34, 2'd2, 32'h1, "R7");
      chk(irq === 1'b1, "R8", {31'd0, irq}, 32'd1);
      acc(1, 8'h2A, 2'd1, 32'hFFFF_0000, "R6");
      chk(irq === 1'b0, "R8", {31'd0, irq}, 32'd0);
      acc(1, 8'h28, 2'd2, 32'h1, "R8");
      acc(1, 8'h24, 2'd0, 32'h1, "R7");
      chk(irq === 1'b0, "R7", {31'd0, irq}, 32'd0);
      acc(1, 8'h25, 2'd0, 32'h100, "R6");
      acc(1, 8'h34, 2'd2, 32'h1, "R7");

      // Random mix (lockdown bit masked off)
      for (int n = 0; n < 600; n++) begin
         logic [7:0]  a;
         logic [1:0]  sz;
         logic [31:0] d;
         bit          w;
         a  = offs[$urandom_range(11)];
         sz = 2'($urandom_range(3));
         if (sz == 2'd0) a = a | 8'($urandom_range(3));
         else if (sz == 2'd1) a = a | (8'($urandom_range(1)) << 1);
         d  = $urandom;
         if ((a & 8'hFC) == 8'h00) d[31] = 1'b0;
         w  = 1'($urandom_range(1));
         acc(w, a, sz, d, "R6");
      end

      // R9: lockdown
      acc(1, 8'h28, 2'd2, 32'h1, "R9");
      acc(1, 8'h00, 2'd2, 32'h8000_0100, "R9");
      acc(1, 8'h00, 2'd2, 32'h0, "R9");
      acc(0, 8'h00, 2'd2, 0, "R9");
      chk(rsp_rdata === 32'h8000_0100, "R9", rsp_rdata, 32'h8000_0100);
      acc(1, 8'h18, 2'd2, 32'd5, "R9");
      acc(1, 8'h1C, 2'd2, 32'hDEAD_BEEF, "R9");
      acc(0, 8'h18, 2'd2, 0, "R9");
      chk(rsp_rdata === 32'd5, "R9", rsp_rdata, 32'd5);
      acc(0, 8'h1C, 2'd2, 0, "R9");
      acc(0, 8'h18, 2'd2, 0, "R9");
      chk(rsp_rdata === 32'd6, "R9", rsp_rdata, 32'd6);
      acc(1, 8'h28, 2'd2, 32'h0, "R9");
      acc(1, 8'h34, 2'd2, 32'h1, "R9");
      chk(irq === 1'b1, "R9", {31'd0, irq}, 32'd1);
      acc(1, 8'h24, 2'd2, 32'h1, "R9");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule